// File: doc/BRIEF.md
# High-Frequency Link Inverter Gating Generator

This block drives the gates of a three-stage DC-to-AC converter. The stages are a full bridge switched at high frequency, a centre-tapped active rectifier, and a full bridge that reverses polarity once per half line cycle. A signed sinusoidal reference arrives as a stream of samples. The block takes the magnitude of the reference and compares it with a symmetric triangular carrier, which gives one pulse per carrier period for the high-frequency bridge.

The rectifier switches follow a divide-by-two of that pulse train. The polarity bridge changes state each time the sign of the reference changes. Every complementary gate pair passes through its own dead-time inserter, so the gate that is switching off always drops before its partner turns on.

The carrier peak and the dead-time are runtime inputs counted in clock cycles. For a 32 kHz carrier, the peak is set to the clock rate divided by 64 kHz. With enable low, the block parks every switch in the off state and holds the carrier at zero.

Top module: `hflink_gate_gen`

## Requirements
- R1: While `rst_n` is low, or one clock edge after `en` is sampled low, all ten gate outputs are 0. The toggle and the carrier count are also cleared.
- R2: The carrier counts 0, 1, … up to `carrier_peak` P and back down to 1, moving by exactly one per enabled cycle. Its period is 2P cycles, so bridge pulses start every 2P cycles.
- R3: The modulating value m is the magnitude of the latest reference sample, taken at the carrier valley. The most negative code saturates to the largest magnitude. The raw PWM is high while m exceeds the carrier count, which is 2m−1 cycles per period for 1 ≤ m ≤ P. For m = 0 the raw PWM never goes high; for m > P it stays high.
- R4: Gate mapping for the high-frequency bridge: `hf_gate[0]` and `hf_gate[3]` form the forward diagonal and follow the raw PWM. `hf_gate[1]` and `hf_gate[2]` form the reverse diagonal and follow its complement.
- R5: A toggle changes state on each rising edge of the raw PWM, before dead-time is applied. `rect_gate[0]` follows the toggle and `rect_gate[1]` its complement. With one pulse per period, `rect_gate[0]` stays high for 2P − d − 1 cycles.
- R6: Let d be `dead_cycles`. When the control of a pair changes, the gate that is turning off drops at the next edge, and its partner rises d + 1 cycles later. A control level lasting L cycles gives a gate pulse of L − d − 1 cycles, and no pulse at all when L ≤ d + 1.
- R7: When the sign bit of a valid sample differs from that of the previous valid sample, the polarity changes. A positive half drives `pol_gate[0]` and `pol_gate[3]`; a negative half drives `pol_gate[1]` and `pol_gate[2]`. Bit 11 (the MSB) of the sample is its sign.
- R8: A valid sample with the same sign as the previous one leaves the polarity gates unchanged.
- R9: The two gates of a complementary pair are never high in the same cycle.
- R10: After reset the polarity is positive. Once enabled, `pol_gate[0]` rises after the dead-time without any sample having been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low parks all gates off |
| ref_valid | input | 1 | Qualifies `ref_sample` for one cycle |
| ref_sample | input | 12 | Signed sinusoidal reference sample |
| carrier_peak | input | 12 | Carrier peak count P (half period in cycles) |
| dead_cycles | input | 8 | Dead-time d in cycles |
| hf_gate | output | 4 | High-frequency bridge gates (R4 mapping) |
| rect_gate | output | 2 | Active rectifier gates |
| pol_gate | output | 4 | Polarity bridge gates (R7 mapping) |

## Verification
A polarity change is due in stages. The sign register takes the new sample at the capturing edge. The outgoing polarity gate falls one edge after that, and the incoming gate rises d + 1 edges after the fall. The bench samples at the falling clock edge in exactly those cycles. For the bridge and rectifier outputs, a change of the reference only reaches the outputs at a later carrier valley. The bench therefore waits three carrier periods after each new setting and only then measures pulse widths and rise-to-rise periods in whole cycles against the R3, R5 and R6 formulas. Disable is checked one edge after `en` falls.

// File: rtl/hflink_pkg.sv
// Package: indices of the three complementary gate pairs shared by the
// gating generator and its bench. Assumes pairs are numbered from zero.
package hflink_pkg;
    localparam int PAIR_HF    = 0;   // high-frequency bridge pair
    localparam int PAIR_RECT  = 1;   // active rectifier pair
    localparam int PAIR_POL   = 2;   // polarity bridge pair
    localparam int NUM_PAIRS  = 3;
endpackage

// File: rtl/hflink_carrier.sv
// Symmetric triangular carrier: counts 0 up to peak and back down to 1.
// Assumes peak >= 1; kill forces the count back to zero, counting up.
module hflink_carrier #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] cnt,
    output logic             valley
);
    logic             up_q;
    logic [CNT_W:0]   cnt_plus;

    assign cnt_plus = {1'b0, cnt} + (CNT_W+1)'(1);
    assign valley   = (cnt == '0);

    // Up/down count with turn-around at the peak and at one.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (up_q) begin
            cnt <= cnt_plus[CNT_W-1:0];
            if (cnt_plus >= {1'b0, peak}) up_q <= 1'b0;
        end else begin
            cnt <= cnt - CNT_W'(1);
            if (cnt <= CNT_W'(1)) up_q <= 1'b1;
        end
    end

    // R2: every enabled step moves the carrier by exactly one count.
    assert_carrier_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !kill |=> (cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/hflink_modulator.sv
// Produces the raw (pre-dead-time) controls: PWM from |reference| against
// the carrier, a divide-by-two toggle for the rectifier, and line polarity.
// Assumes the carrier count is registered and valley marks count zero.
module hflink_modulator #(
    parameter int REF_W = 12,
    parameter int CNT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    kill,
    input  logic                    ref_valid,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [CNT_W-1:0]        cnt,
    input  logic                    valley,
    output logic                    pwm_raw,
    output logic                    tog_raw,
    output logic                    pol_raw
);
    localparam int MAG_W = REF_W - 1;
    localparam int CMP_W = (MAG_W > CNT_W) ? MAG_W : CNT_W;

    logic signed [REF_W-1:0] ref_q;
    logic                    sign_q;
    logic [MAG_W-1:0]        mod_q;
    logic                    pwm_next;

    // Saturating magnitude of a signed sample.
    function automatic logic [MAG_W-1:0] mag_sat(input logic signed [REF_W-1:0] v);
        logic [REF_W-1:0] n;
        if (!v[REF_W-1]) return v[MAG_W-1:0];
        n = -v;
        if (n[REF_W-1]) return '1;
        return n[MAG_W-1:0];
    endfunction

    assign pwm_next = CMP_W'(mod_q) > CMP_W'(cnt);

    // Track the reference and flip polarity at each sign change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            sign_q  <= 1'b0;
            pol_raw <= 1'b1;
        end else if (ref_valid) begin
            ref_q  <= ref_sample;
            sign_q <= ref_sample[REF_W-1];
            if (ref_sample[REF_W-1] != sign_q) pol_raw <= ~ref_sample[REF_W-1];
        end
    end

    // Latch magnitude at the valley, compare, and divide the PWM by two.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            mod_q   <= '0;
            pwm_raw <= 1'b0;
            tog_raw <= 1'b0;
        end else begin
            if (valley) mod_q <= mag_sat(ref_q);
            pwm_raw <= pwm_next;
            if (pwm_next && !pwm_raw) tog_raw <= ~tog_raw;
        end
    end

    // R5: the toggle only moves on a rising edge of the raw PWM.
    assert_toggle_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tog_raw) && $past(rst_n) && !$past(kill)) |-> (pwm_raw && !$past(pwm_raw)));
    // R8: polarity changes only when a valid sample was taken.
    assert_pol_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pol_raw) && $past(rst_n)) |-> $past(ref_valid));
endmodule

// File: rtl/hflink_deadtime.sv
// Dead-time inserter for one complementary pair: on any change of the
// control both gates drop, then the matching gate turns on after
// dead+1 cycles if the control held. Assumes dead is quasi-static.
module hflink_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill,
    input  logic [DT_W-1:0] dead,
    input  logic            ctrl,
    output logic            gate_on,
    output logic            gate_off
);
    logic            last_q;
    logic [DT_W-1:0] wait_q;

    // Blank both gates on a change, count the dead-time, then drive.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            last_q   <= 1'b0;
            wait_q   <= dead;
            gate_on  <= 1'b0;
            gate_off <= 1'b0;
        end else if (ctrl != last_q) begin
            last_q   <= ctrl;
            wait_q   <= dead;
            gate_on  <= 1'b0;
            gate_off <= 1'b0;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - DT_W'(1);
        end else begin
            gate_on  <= last_q;
            gate_off <= ~last_q;
        end
    end

    // R9: the pair never conducts together.
    assert_pair_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_on && gate_off));
    // R6: a gate only turns on after its partner was already off.
    assert_gap_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> !$past(gate_off));
    assert_gap_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_off) |-> !$past(gate_on));
endmodule

// File: rtl/hflink_gate_gen.sv
// Top: carrier, modulator and one dead-time inserter per gate pair,
// mapped onto ten switch gates. Assumes synchronous active-low reset.
module hflink_gate_gen #(
    parameter int REF_W = 12,
    parameter int CNT_W = 12,
    parameter int DT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    ref_valid,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [CNT_W-1:0]        carrier_peak,
    input  logic [DT_W-1:0]         dead_cycles,
    output logic [3:0]              hf_gate,
    output logic [1:0]              rect_gate,
    output logic [3:0]              pol_gate
);
    import hflink_pkg::*;

    logic                 kill;
    logic [CNT_W-1:0]     cnt;
    logic                 valley;
    logic                 pwm_raw, tog_raw, pol_raw;
    logic [NUM_PAIRS-1:0] ctrl, g_on, g_off;

    assign kill = ~en;

    hflink_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .kill(kill), .peak(carrier_peak),
        .cnt(cnt), .valley(valley)
    );

    hflink_modulator #(.REF_W(REF_W), .CNT_W(CNT_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .kill(kill), .ref_valid(ref_valid),
        .ref_sample(ref_sample), .cnt(cnt), .valley(valley),
        .pwm_raw(pwm_raw), .tog_raw(tog_raw), .pol_raw(pol_raw)
    );

    assign ctrl[PAIR_HF]   = pwm_raw;
    assign ctrl[PAIR_RECT] = tog_raw;
    assign ctrl[PAIR_POL]  = pol_raw;

    // One dead-time inserter per complementary pair.
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        hflink_deadtime #(.DT_W(DT_W)) u_dt (
            .clk(clk), .rst_n(rst_n), .kill(kill), .dead(dead_cycles),
            .ctrl(ctrl[i]), .gate_on(g_on[i]), .gate_off(g_off[i])
        );
    end

    assign hf_gate   = {g_on[PAIR_HF],  g_off[PAIR_HF],  g_off[PAIR_HF],  g_on[PAIR_HF]};
    assign rect_gate = {g_off[PAIR_RECT], g_on[PAIR_RECT]};
    assign pol_gate  = {g_on[PAIR_POL], g_off[PAIR_POL], g_off[PAIR_POL], g_on[PAIR_POL]};

    // R1: disabling parks every switch off at the next edge.
    assert_idle_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hf_gate == 4'b0 && rect_gate == 2'b0 && pol_gate == 4'b0));
endmodule

// File: tb/hflink_gate_gen_tb.sv
`timescale 1ns/1ps
module hflink_gate_gen_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              ref_valid = 1'b0;
    logic signed [11:0] ref_sample = '0;
    logic [11:0]       carrier_peak = 12'd20;
    logic [7:0]        dead_cycles = 8'd3;
    logic [3:0]        hf_gate;
    logic [1:0]        rect_gate;
    logic [3:0]        pol_gate;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    hflink_gate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ref_valid(ref_valid),
        .ref_sample(ref_sample), .carrier_peak(carrier_peak),
        .dead_cycles(dead_cycles), .hf_gate(hf_gate),
        .rect_gate(rect_gate), .pol_gate(pol_gate)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push an expected item.
    task automatic push_exp(input string req, input int val);
        exp_q.push_back('{req, val});
    endtask

    // Monitor side: pop the oldest expected item and compare.
    task automatic pop_cmp(input int actual);
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (actual != e.val) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", e.req, actual, e.val);
        end
    endtask

    function automatic logic sig(input int k);
        case (k)
            0: return hf_gate[0];
            1: return hf_gate[1];
            2: return rect_gate[0];
            default: return pol_gate[1];
        endcase
    endfunction

    // Width of the next complete high pulse of the selected gate.
    task automatic width_of(input int k, output int w);
        int g = 0;
        while (sig(k) != 1'b0 && g < 3000) begin tick(1); g++; end
        while (sig(k) != 1'b1 && g < 3000) begin tick(1); g++; end
        w = 0;
        while (sig(k) == 1'b1 && w < 3000) begin tick(1); w++; end
    endtask

    // Cycles from one rise of hf_gate[0] to the next.
    task automatic period_of(output int p);
        int w;
        width_of(0, w);
        p = w;
        while (hf_gate[0] != 1'b1 && p < 3000) begin tick(1); p++; end
    endtask

    // Count cycles a gate is high over a window.
    task automatic high_count(input int k, input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            if (sig(k)) c++;
            tick(1);
        end
    endtask

    task automatic send(input logic signed [11:0] v);
        @(negedge clk);
        ref_sample = v;
        ref_valid  = 1'b1;
        @(negedge clk);
        ref_valid  = 1'b0;
    endtask

    initial begin
        #(5ns * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w;
        tick(3);
        // R1: reset state
        push_exp("R1 reset all gates off", 0);
        pop_cmp({hf_gate, rect_gate, pol_gate});
        @(negedge clk); rst_n = 1'b1; en = 1'b1;
        tick(8);
        // R10: positive polarity without any sample
        push_exp("R10 pol_gate after enable", 4'b1001);
        pop_cmp(pol_gate);

        // R3/R6: m=6, P=20, d=3
        send(12'sd6); tick(120);
        push_exp("R3 R6 forward width m=6 d=3", 7);
        width_of(0, w); pop_cmp(w);
        push_exp("R6 reverse width m=6 d=3", 25);
        width_of(1, w); pop_cmp(w);
        push_exp("R2 carrier period", 40);
        period_of(w); pop_cmp(w);
        push_exp("R4 diagonal mapping", 1);
        pop_cmp(int'(hf_gate[3] == hf_gate[0] && hf_gate[2] == hf_gate[1]));
        push_exp("R5 rectifier width", 36);
        width_of(2, w); pop_cmp(w);
        push_exp("R9 rectifier pair exclusive", 0);
        pop_cmp(int'(rect_gate[0] & rect_gate[1]));

        // R6: zero dead-time
        @(negedge clk); dead_cycles = 8'd0; tick(120);
        push_exp("R6 forward width d=0", 10);
        width_of(0, w); pop_cmp(w);

        // R6: short pulse swallowed (L=3, d=3)
        @(negedge clk); dead_cycles = 8'd3;
        send(12'sd2); tick(120);
        push_exp("R6 short pulse suppressed", 0);
        high_count(0, 120, w); pop_cmp(w);

        // R6: one cycle left (L=5, d=3)
        send(12'sd3); tick(120);
        push_exp("R6 minimal pulse width", 1);
        width_of(0, w); pop_cmp(w);

        // R3: m=0 never on, m>P always on
        send(12'sd0); tick(120);
        push_exp("R3 zero reference", 0);
        high_count(0, 120, w); pop_cmp(w);
        send(12'sd30); tick(120);
        push_exp("R3 reference above peak", 120);
        high_count(0, 120, w); pop_cmp(w);

        // R7: crossing to negative, timed
        @(negedge clk); ref_sample = -12'sd100; ref_valid = 1'b1;
        @(negedge clk); ref_valid = 1'b0;
        @(negedge clk);
        push_exp("R7 both polarity gates blanked", 0);
        pop_cmp(pol_gate);
        tick(3);
        push_exp("R7 negative gate still off in dead-time", 0);
        pop_cmp(pol_gate[1]);
        tick(1);
        push_exp("R7 negative half gates", 4'b0110);
        pop_cmp(pol_gate);

        // R8: same sign ignored
        send(-12'sd50); tick(8);
        push_exp("R8 same sign no change", 4'b0110);
        pop_cmp(pol_gate);

        // R3: most negative code saturates
        send(-12'sd2048); tick(120);
        push_exp("R3 saturated magnitude", 120);
        high_count(0, 120, w); pop_cmp(w);

        // R7: back to positive
        send(12'sd40); tick(6);
        push_exp("R7 positive half gates", 4'b1001);
        pop_cmp(pol_gate);

        // R1: disable parks all gates
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        push_exp("R1 disabled all off", 0);
        pop_cmp({hf_gate, rect_gate, pol_gate});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule